// File: doc/BRIEF.md
# Processor status flag unit

This block keeps the flag word of a small 16-bit processor. After an 8-bit or 16-bit add or subtract, the datapath presents the two operands, the result it produced, the operation kind and the width. On a load strobe the unit then captures six status flags: carry, parity, auxiliary carry, zero, sign and overflow. Three control flags sit beside them: trap (single-step request), interrupt enable and string direction. Each one is set or cleared by its own strobe and otherwise holds its value.

The unit packs all nine flags into a 16-bit word at fixed positions. The control flags are also brought out as separate pins so that the sequencer and the interrupt logic can read them directly. The carry, overflow and auxiliary carry are worked out from the operand and result bits at the boundary in question, so the adder does not have to export its internal carries.

Top module: `flag_word_unit`

## Requirements
- R1: After reset is asserted, `flags_o` reads 16'h0002 and `trap_o`, `int_en_o` and `dir_o` are 0.
- R2: The positions in `flags_o` are: carry 0, parity 2, auxiliary carry 4, zero 6, sign 7, trap 8, interrupt enable 9, direction 10 and overflow 11. Bit 1 always reads 1 and bits 3, 5, 12, 13, 14 and 15 always read 0.
- R3: When a load is captured, the sign flag equals the result's top bit at the selected width: bit 15 when `wide_i`=1 and bit 7 when `wide_i`=0.
- R4: When a load is captured, the zero flag is 1 only if every result bit inside the selected width is 0. Result bits above bit 7 are ignored when `wide_i`=0.
- R5: When a load is captured, the auxiliary carry is the carry out of bit 3 for an add, or the borrow into bit 4 for a subtract (`sub_i`=1).
- R6: When a load is captured, the parity flag is 1 when result bits 7..0 hold an even number of ones, and 0 when they hold an odd number, at either width.
- R7: When a load is captured, the carry flag is the carry out of the top bit of the selected width for an add, and the borrow for a subtract (unsigned `opa_i` < `opb_i`).
- R8: When a load is captured, the overflow flag is 1 when the two's-complement result of the operation does not fit in the selected width.
- R9: The status flags change only on a clock edge where `load_i`=1. The new values appear in `flags_o` after that edge.
- R10: For each control flag (index 0 trap, 1 interrupt enable, 2 direction), `ctl_set_i` makes it 1 and `ctl_clr_i` makes it 0 after the edge. Set wins when both are high, and the flag holds when neither is high. `trap_o`, `int_en_o` and `dir_o` equal the matching bits of `flags_o`.
- R11: The control strobes do not change the status flags, and a load does not change the control flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Capture the status flags from this cycle's operation |
| sub_i | input | 1 | 1: the operation was a subtract, 0: an add |
| wide_i | input | 1 | 1: 16-bit operation, 0: 8-bit operation |
| opa_i | input | 16 | First operand (minuend for a subtract) |
| opb_i | input | 16 | Second operand (subtrahend for a subtract) |
| res_i | input | 16 | Result produced by the datapath |
| ctl_set_i | input | 3 | Set strobes for the control flags: 0 trap, 1 interrupt enable, 2 direction |
| ctl_clr_i | input | 3 | Clear strobes for the control flags, same order |
| flags_o | output | 16 | Packed flag word |
| trap_o | output | 1 | Trap (single-step) flag |
| int_en_o | output | 1 | Interrupt enable flag |
| dir_o | output | 1 | Direction flag, 1 = descending addresses |

## Verification
Every result lands one edge after its stimulus: the status flags and the control flags are each a single register stage away from the inputs. The bench drives inputs on the falling edge, and its reference model updates on the same rising edge the design uses. Every output field is compared on the next falling edge, so each check lands exactly one edge after its stimulus. Stimulus includes cycles without a load and with upper-byte noise during 8-bit operations, so the hold and ignore requirements are observed on the ports.

// File: rtl/flag_word_pkg.sv
package flag_word_pkg;
  localparam int FLAG_W   = 16;
  localparam int CF_POS   = 0;
  localparam int ONE_POS  = 1;
  localparam int PF_POS   = 2;
  localparam int AF_POS   = 4;
  localparam int ZF_POS   = 6;
  localparam int SF_POS   = 7;
  localparam int TF_POS   = 8;
  localparam int IF_POS   = 9;
  localparam int DF_POS   = 10;
  localparam int OF_POS   = 11;
  localparam int CTL_N    = 3;

  typedef enum int {
    CTL_TRAP = 0,
    CTL_INTR = 1,
    CTL_DIR  = 2
  } ctl_idx_e;

  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } status_t;
endpackage

// File: rtl/flag_status_calc.sv
module flag_status_calc
  import flag_word_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int PAR_W    = 8
) (
  input  logic              sub_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [DATA_W-1:0] res_i,
  output status_t           st_o
);
  localparam int NIB = NARROW_W / 2;

  logic a_m, b_m, r_m;

  always_comb begin
    a_m = wide_i ? opa_i[DATA_W-1] : opa_i[NARROW_W-1];
    b_m = wide_i ? opb_i[DATA_W-1] : opb_i[NARROW_W-1];
    r_m = wide_i ? res_i[DATA_W-1] : res_i[NARROW_W-1];

    st_o.sgn = r_m;
    st_o.zro = wide_i ? ~|res_i : ~|res_i[NARROW_W-1:0];
    st_o.par = ~^res_i[PAR_W-1:0];
    // carry/borrow into bit NIB recovered from the sum bit
    st_o.aux = opa_i[NIB] ^ opb_i[NIB] ^ res_i[NIB];
    if (sub_i) begin
      st_o.cry = (~a_m & b_m) | ((~a_m | b_m) & r_m);
      st_o.ovf = (a_m ^ b_m) & (r_m ^ a_m);
    end else begin
      st_o.cry = (a_m & b_m) | ((a_m | b_m) & ~r_m);
      st_o.ovf = ~(a_m ^ b_m) & (r_m ^ a_m);
    end
  end
endmodule

// File: rtl/flag_ctrl_bank.sv
module flag_ctrl_bank #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[k] <= 1'b0;
      else if (set_i[k])  q_o[k] <= 1'b1;
      else if (clr_i[k])  q_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/flag_word_pack.sv
module flag_word_pack
  import flag_word_pkg::*;
(
  input  status_t           st_i,
  input  logic [CTL_N-1:0]  ctl_i,
  output logic [FLAG_W-1:0] word_o
);
  always_comb begin
    word_o          = '0;
    word_o[ONE_POS] = 1'b1;
    word_o[CF_POS]  = st_i.cry;
    word_o[PF_POS]  = st_i.par;
    word_o[AF_POS]  = st_i.aux;
    word_o[ZF_POS]  = st_i.zro;
    word_o[SF_POS]  = st_i.sgn;
    word_o[OF_POS]  = st_i.ovf;
    word_o[TF_POS]  = ctl_i[CTL_TRAP];
    word_o[IF_POS]  = ctl_i[CTL_INTR];
    word_o[DF_POS]  = ctl_i[CTL_DIR];
  end
endmodule

// File: rtl/flag_word_unit.sv
module flag_word_unit
  import flag_word_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic                    sub_i,
  input  logic                    wide_i,
  input  logic [DATA_W-1:0]       opa_i,
  input  logic [DATA_W-1:0]       opb_i,
  input  logic [DATA_W-1:0]       res_i,
  input  logic [CTL_N-1:0]        ctl_set_i,
  input  logic [CTL_N-1:0]        ctl_clr_i,
  output logic [FLAG_W-1:0]       flags_o,
  output logic                    trap_o,
  output logic                    int_en_o,
  output logic                    dir_o
);
  status_t          st_d, st_q;
  logic [CTL_N-1:0] ctl_q;

  flag_status_calc #(
    .DATA_W  (DATA_W),
    .NARROW_W(NARROW_W),
    .PAR_W   (NARROW_W)
  ) i_calc (
    .sub_i (sub_i),
    .wide_i(wide_i),
    .opa_i (opa_i),
    .opb_i (opb_i),
    .res_i (res_i),
    .st_o  (st_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= '0;
    else if (load_i) st_q <= st_d;
  end

  flag_ctrl_bank #(.N(CTL_N)) i_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (ctl_set_i),
    .clr_i (ctl_clr_i),
    .q_o   (ctl_q)
  );

  flag_word_pack i_pack (
    .st_i  (st_q),
    .ctl_i (ctl_q),
    .word_o(flags_o)
  );

  assign trap_o   = ctl_q[CTL_TRAP];
  assign int_en_o = ctl_q[CTL_INTR];
  assign dir_o    = ctl_q[CTL_DIR];
endmodule

// File: rtl/flag_word_chk.sv
module flag_word_chk
  import flag_word_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                load_i,
  input logic                sub_i,
  input logic                wide_i,
  input logic [DATA_W-1:0]   opa_i,
  input logic [DATA_W-1:0]   opb_i,
  input logic [DATA_W-1:0]   res_i,
  input logic [CTL_N-1:0]    ctl_set_i,
  input logic [CTL_N-1:0]    ctl_clr_i,
  input logic [FLAG_W-1:0]   flags_o,
  input logic                trap_o,
  input logic                int_en_o,
  input logic                dir_o
);
  logic [5:0] st_bits;
  assign st_bits = {flags_o[OF_POS], flags_o[SF_POS], flags_o[ZF_POS],
                    flags_o[AF_POS], flags_o[PF_POS], flags_o[CF_POS]};

  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(st_bits)) else $error("status moved without load"); // R9
  AST_CTRL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_set_i == '0 && ctl_clr_i == '0) |=> $stable({dir_o, int_en_o, trap_o})) else $error("control moved"); // R10
  AST_TRAP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_set_i[CTL_TRAP] |=> trap_o) else $error("trap not set"); // R10
  AST_DIR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_clr_i[CTL_DIR] && !ctl_set_i[CTL_DIR]) |=> !dir_o) else $error("dir not cleared"); // R10
  AST_PARITY_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> flags_o[PF_POS] == ~^$past(res_i[7:0])) else $error("parity"); // R6
  AST_ZERO_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wide_i && res_i[NARROW_W-1:0] == '0) |=> flags_o[ZF_POS]) else $error("zero narrow"); // R4
  AST_SIGN_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && wide_i) |=> flags_o[SF_POS] == $past(res_i[DATA_W-1])) else $error("sign wide"); // R3
endmodule

bind flag_word_unit flag_word_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_chk (.*);

// File: tb/test_flag_word_unit.sv
module test_flag_word_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_i = 1'b0, sub_i = 1'b0, wide_i = 1'b0;
  logic [15:0] opa_i = '0, opb_i = '0, res_i = '0;
  logic [2:0]  ctl_set_i = '0, ctl_clr_i = '0;
  logic [15:0] flags_o;
  logic        trap_o, int_en_o, dir_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  bit m_cf, m_pf, m_af, m_zf, m_sf, m_of;
  bit [2:0] m_ctl;

  always #2.5 clk_i = ~clk_i;

  flag_word_unit i_flag_word_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {m_cf, m_pf, m_af, m_zf, m_sf, m_of} = '0;
      m_ctl = '0;
    end else begin
      if (load_i) begin
        int w, a, b, r, sa, sb, s, half;
        w = wide_i ? 16 : 8;
        half = 1 << (w - 1);
        a = opa_i & ((1 << w) - 1);
        b = opb_i & ((1 << w) - 1);
        r = res_i & ((1 << w) - 1);
        sa = (a >= half) ? a - 2 * half : a;
        sb = (b >= half) ? b - 2 * half : b;
        if (sub_i) begin
          m_cf = a < b;
          m_af = (a & 15) < (b & 15);
          s = sa - sb;
        end else begin
          m_cf = (a + b) >= (1 << w);
          m_af = ((a & 15) + (b & 15)) > 15;
          s = sa + sb;
        end
        m_of = (s < -half) || (s >= half);
        m_zf = (r == 0);
        m_sf = (r >= half);
        m_pf = ($countones(res_i[7:0]) % 2) == 0;
      end
      for (int k = 0; k < 3; k++)
        if (ctl_set_i[k]) m_ctl[k] = 1'b1;
        else if (ctl_clr_i[k]) m_ctl[k] = 1'b0;
    end
  end

  task automatic compare_all(input bit loaded);
    string sr;
    sr = loaded ? "" : " R9";
    chk({"R7 carry", sr},   flags_o[0],  m_cf);
    chk({"R6 parity", sr},  flags_o[2],  m_pf);
    chk({"R5 aux", sr},     flags_o[4],  m_af);
    chk({"R4 zero", sr},    flags_o[6],  m_zf);
    chk({"R3 sign", sr},    flags_o[7],  m_sf);
    chk({"R8 ovf", sr},     flags_o[11], m_of);
    chk("R2 fixed bits", {flags_o[15:12], flags_o[5], flags_o[3], flags_o[1]}, 7'b0000001);
    chk("R10 ctl word", flags_o[10:8], m_ctl);
    chk("R10 ctl pins", {dir_o, int_en_o, trap_o}, m_ctl);
  endtask

  // drive at negedge; result due after next posedge, checked at following negedge
  task automatic op(input bit wide, input bit sub, input int a, input int b,
                    input logic [15:0] noise = 16'h0);
    int w;
    logic [15:0] r;
    w = wide ? 16 : 8;
    r = sub ? 16'(a - b) : 16'(a + b);
    if (!wide) r = {noise[15:8], r[7:0]};
    load_i = 1'b1; sub_i = sub; wide_i = wide;
    opa_i = 16'(a); opb_i = 16'(b); res_i = r;
    if (!wide) begin opa_i[15:8] = noise[7:0]; opb_i[15:8] = noise[15:8]; end
    @(negedge clk_i);
    load_i = 1'b0;
    compare_all(1'b1);
  endtask

  task automatic ctl(input logic [2:0] s, input logic [2:0] c);
    logic [5:0] st_before;
    st_before = {flags_o[11], flags_o[7], flags_o[6], flags_o[4], flags_o[2], flags_o[0]};
    ctl_set_i = s; ctl_clr_i = c;
    // noisy operand inputs without load
    opa_i = 16'hA5A5; opb_i = 16'h5A5A; res_i = 16'h0000; wide_i = 1'b1;
    @(negedge clk_i);
    ctl_set_i = '0; ctl_clr_i = '0;
    compare_all(1'b0);
    chk("R11 status untouched by ctl", {flags_o[11], flags_o[7], flags_o[6], flags_o[4], flags_o[2], flags_o[0]}, st_before);
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset word", flags_o, 16'h0002);
    chk("R1 reset pins", {dir_o, int_en_o, trap_o}, 3'b000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all(1'b0);

    op(0, 0, 8'h7F, 8'h01);            // R8 ovf, R5 aux, R3 sign
    op(0, 0, 8'hFF, 8'h01, 16'hC3C3);  // R4 zero w/ upper noise, R7 carry
    op(1, 0, 16'hFFFF, 16'h0001);      // wide zero + carry
    op(1, 0, 16'h0080, 16'h0080);      // R4 low byte zero but wide nonzero
    op(1, 1, 16'h8000, 16'h0001);      // R8 wide sub ovf
    op(0, 1, 8'h00, 8'h01, 16'h1234);  // R7 borrow, R5 aux borrow
    op(0, 1, 8'h10, 8'h01);            // R5 aux borrow only
    op(1, 0, 16'h7000, 16'h1000);      // R3 sign wide, R8
    op(0, 0, 8'h03, 8'h00);            // R6 parity even
    op(0, 0, 8'h01, 8'h00);            // R6 parity odd

    // R9: hold while load low with changing inputs
    repeat (3) begin
      opa_i = 16'h1111; opb_i = 16'hEEEE; res_i = 16'hFFFF; sub_i = 1'b1;
      @(negedge clk_i);
      compare_all(1'b0);
    end

    // R10, R11
    ctl(3'b111, 3'b000);
    ctl(3'b000, 3'b010);
    ctl(3'b101, 3'b101);   // set wins
    ctl(3'b000, 3'b000);   // hold
    ctl(3'b000, 3'b111);
    ctl(3'b100, 3'b000);

    // R11: load leaves control flags
    op(1, 0, 16'h0001, 16'h0001);

    for (int i = 0; i < 400; i++) begin
      if (i % 7 == 3) ctl(3'($urandom), 3'($urandom));
      else op($urandom % 2, $urandom % 2, $urandom & 16'hFFFF, $urandom & 16'hFFFF,
              16'($urandom));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule